// File: doc/BRIEF.md
# Fixed-Point Quantizer

This block narrows a wide signed fixed-point sample to an 8-bit signed word with one integer bit. The 8-bit word is two's complement. It covers -1.0 up to 1.0 minus 2^-7, in steps of 2^-7. The input is a 24-bit two's complement value with 8 integer bits and 16 fraction bits. The block drops nine fraction bits, applies a rounding rule, and then handles any result that falls outside the output range. Two mode inputs choose the rounding rule and the out-of-range rule on each sample.

The result is registered. It appears together with two flags one clock after a sample is presented with its valid bit. One flag says the quantized value left the output range. The other says some of the dropped bits were nonzero. Values can be streamed every cycle. When valid is low, the previous result is held.

Top module: `fixq_top`

## Requirements
- R1: A synchronous active-high reset clears outValid, outData, outOvf and outInexact to zero.
- R2: outValid equals inValid delayed by one clock. A result is captured only when inValid is 1. While inValid is 0, outData, outOvf and outInexact hold their values.
- R3: quantMode code 0 rounds to the nearest step, and an exact half step goes up toward positive infinity. For example, input -256 (that is, -2^-8) gives 0.
- R4: quantMode code 1 rounds toward zero. A nonzero dropped part on a negative value raises the result by one step, and a positive value is floored.
- R5: quantMode code 2 truncates, which floors the value toward negative infinity. For example, input -256 gives 8'hFF.
- R6: ovfMode code 0 saturates. A quantized value above 127 steps gives 8'h7F, and one below -128 steps gives 8'h80.
- R7: ovfMode code 1 gives 8'h00 for any out-of-range quantized value.
- R8: ovfMode code 2 wraps, so the output is the low 8 bits of the quantized value.
- R9: outOvf is 1 when the quantized value is outside [-128, 127] steps, whatever ovfMode is. This includes a round-up carry: input 16'hFF00 in round mode gives 8'h7F with outOvf set under saturation.
- R10: outInexact is 1 exactly when any of the nine dropped input bits (inData[8:0]) was nonzero.
- R11: Code 3 on quantMode behaves as code 0, and code 3 on ovfMode behaves as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Input sample is valid this cycle |
| inData | input | 24 | Signed input: 8 integer bits, 16 fraction bits |
| quantMode | input | 2 | 0 round-half-up, 1 toward zero, 2 truncate, 3 as 0 |
| ovfMode | input | 2 | 0 saturate, 1 zero on overflow, 2 wrap, 3 as 0 |
| outValid | output | 1 | Result valid, one cycle after inValid |
| outData | output | 8 | Signed result: 1 integer bit, 7 fraction bits |
| outOvf | output | 1 | Quantized value was out of range |
| outInexact | output | 1 | Dropped fraction bits were nonzero |

## Verification
The directed cases aim at the half-step boundary on both signs. A design that rounds half away from zero, or that floors instead of rounding, returns -1 step instead of 0 for -2^-8. The round-up carry at +127.5 steps is also covered: a design that checks the range before rounding misses the overflow and wraps to 8'h80. Negative inputs with a small dropped part show whether toward-zero and truncate were swapped. Random mixes of all mode codes, including code 3, expose a design that decodes the spare code as wrap or truncate, or that sets the overflow flag only in saturate mode.

// File: rtl/fixq_pkg.sv
package fixq_pkg;

  typedef enum logic [1:0] {
    Q_ROUND = 2'd0,
    Q_ZERO  = 2'd1,
    Q_TRUNC = 2'd2
  } quant_e;

  typedef enum logic [1:0] {
    O_SAT   = 2'd0,
    O_SATZ  = 2'd1,
    O_WRAP  = 2'd2
  } ovf_e;

  typedef struct packed {
    logic   load;
    quant_e quantSel;
    ovf_e   ovfSel;
  } strobe_t;

endpackage

// File: rtl/fixq_ctrl.sv
module fixq_ctrl
  import fixq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [1:0] quantMode,
  input  logic [1:0] ovfMode,
  output strobe_t    strobes,
  output logic       outValid
);

  quant_e quantDec;
  ovf_e   ovfDec;

  // Spare code 3 folds onto code 0 for both mode fields
  always_comb begin
    unique case (quantMode)
      2'd1:    quantDec = Q_ZERO;
      2'd2:    quantDec = Q_TRUNC;
      default: quantDec = Q_ROUND;
    endcase
    unique case (ovfMode)
      2'd1:    ovfDec = O_SATZ;
      2'd2:    ovfDec = O_WRAP;
      default: ovfDec = O_SAT;
    endcase
  end

  always_comb begin
    strobes.load     = inValid;
    strobes.quantSel = quantDec;
    strobes.ovfSel   = ovfDec;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

endmodule

// File: rtl/fixq_round.sv
module fixq_round
  import fixq_pkg::*;
#(
  parameter int IN_W = 24,
  parameter int DROP = 9,
  localparam int KEEP_W = IN_W - DROP,
  localparam int Q_W    = KEEP_W + 1
) (
  input  logic [IN_W-1:0]       dataIn,
  input  quant_e                quantSel,
  output logic signed [Q_W-1:0] qVal,
  output logic                  lostBits
);

  logic signed [Q_W-1:0] keptVal;
  logic [DROP-1:0]       dropPart;
  logic                  bumpUp;

  always_comb begin
    // Arithmetic floor: sign-extend the retained high bits by one bit
    keptVal  = {dataIn[IN_W-1], dataIn[IN_W-1:DROP]};
    dropPart = dataIn[DROP-1:0];
    lostBits = |dropPart;
    unique case (quantSel)
      Q_ROUND: bumpUp = dropPart[DROP-1];
      Q_ZERO:  bumpUp = dataIn[IN_W-1] & lostBits;
      default: bumpUp = 1'b0;
    endcase
    qVal = keptVal + $signed({{(Q_W-1){1'b0}}, bumpUp});
  end

endmodule

// File: rtl/fixq_limit.sv
module fixq_limit
  import fixq_pkg::*;
#(
  parameter int Q_W   = 16,
  parameter int OUT_W = 8
) (
  input  logic signed [Q_W-1:0] qVal,
  input  ovf_e                  ovfSel,
  output logic [OUT_W-1:0]      limited,
  output logic                  outOfRange
);

  localparam logic signed [Q_W-1:0] MAX_V = Q_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
  localparam logic signed [Q_W-1:0] MIN_V = -MAX_V - Q_W'(1);
  localparam logic [OUT_W-1:0] MAX_CODE = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] MIN_CODE = {1'b1, {(OUT_W-1){1'b0}}};

  always_comb begin
    outOfRange = (qVal > MAX_V) || (qVal < MIN_V);
    limited    = qVal[OUT_W-1:0];
    if (outOfRange) begin
      unique case (ovfSel)
        O_SATZ:  limited = '0;
        O_WRAP:  limited = qVal[OUT_W-1:0];
        default: limited = qVal[Q_W-1] ? MIN_CODE : MAX_CODE;
      endcase
    end
  end

endmodule

// File: rtl/fixq_datapath.sv
module fixq_datapath
  import fixq_pkg::*;
#(
  parameter int IN_W     = 24,
  parameter int IN_FRAC  = 16,
  parameter int OUT_W    = 8,
  parameter int OUT_FRAC = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          strobes,
  input  logic [IN_W-1:0]  inData,
  output logic [OUT_W-1:0] outData,
  output logic             outOvf,
  output logic             outInexact
);

  localparam int DROP = IN_FRAC - OUT_FRAC;
  localparam int Q_W  = IN_W - DROP + 1;

  logic signed [Q_W-1:0] qVal;
  logic                  lostBits;
  logic [OUT_W-1:0]      limited;
  logic                  outOfRange;

  fixq_round #(.IN_W(IN_W), .DROP(DROP)) u_round (
    .dataIn   (inData),
    .quantSel (strobes.quantSel),
    .qVal     (qVal),
    .lostBits (lostBits)
  );

  fixq_limit #(.Q_W(Q_W), .OUT_W(OUT_W)) u_limit (
    .qVal       (qVal),
    .ovfSel     (strobes.ovfSel),
    .limited    (limited),
    .outOfRange (outOfRange)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      outData    <= '0;
      outOvf     <= 1'b0;
      outInexact <= 1'b0;
    end else if (strobes.load) begin
      outData    <= limited;
      outOvf     <= outOfRange;
      outInexact <= lostBits;
    end
  end

endmodule

// File: rtl/fixq_top.sv
module fixq_top
  import fixq_pkg::*;
#(
  parameter int IN_W     = 24,
  parameter int IN_FRAC  = 16,
  parameter int OUT_W    = 8,
  parameter int OUT_FRAC = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [IN_W-1:0]  inData,
  input  logic [1:0]       quantMode,
  input  logic [1:0]       ovfMode,
  output logic             outValid,
  output logic [OUT_W-1:0] outData,
  output logic             outOvf,
  output logic             outInexact
);

  strobe_t strobes;

  fixq_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .quantMode (quantMode),
    .ovfMode   (ovfMode),
    .strobes   (strobes),
    .outValid  (outValid)
  );

  fixq_datapath #(
    .IN_W(IN_W), .IN_FRAC(IN_FRAC), .OUT_W(OUT_W), .OUT_FRAC(OUT_FRAC)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .inData     (inData),
    .outData    (outData),
    .outOvf     (outOvf),
    .outInexact (outInexact)
  );

endmodule

// File: rtl/fixq_checker.sv
module fixq_checker #(
  parameter int IN_W     = 24,
  parameter int IN_FRAC  = 16,
  parameter int OUT_W    = 8,
  parameter int OUT_FRAC = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic [IN_W-1:0]  inData,
  input logic [1:0]       ovfMode,
  input logic             outValid,
  input logic [OUT_W-1:0] outData,
  input logic             outOvf,
  input logic             outInexact
);

  localparam int DROP = IN_FRAC - OUT_FRAC;
  localparam logic [OUT_W-1:0] MAX_CODE = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] MIN_CODE = {1'b1, {(OUT_W-1){1'b0}}};

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!outValid && outData == '0 && !outOvf && !outInexact));

  a_r2_valid_follow: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  a_r2_valid_drop: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  a_r2_hold_result: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ($stable(outData) && $stable(outOvf) && $stable(outInexact)));

  a_r10_exact_input: assert property (@(posedge clk) disable iff (rst)
    (inValid && inData[DROP-1:0] == '0) |=> !outInexact);

  a_r7_zero_on_ovf: assert property (@(posedge clk) disable iff (rst)
    (outValid && outOvf && $past(ovfMode) == 2'd1) |-> outData == '0);

  a_r6_clamp_on_ovf: assert property (@(posedge clk) disable iff (rst)
    (outValid && outOvf && ($past(ovfMode) == 2'd0 || $past(ovfMode) == 2'd3))
      |-> (outData == MAX_CODE || outData == MIN_CODE));

endmodule

bind fixq_top fixq_checker #(
  .IN_W(IN_W), .IN_FRAC(IN_FRAC), .OUT_W(OUT_W), .OUT_FRAC(OUT_FRAC)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .inValid    (inValid),
  .inData     (inData),
  .ovfMode    (ovfMode),
  .outValid   (outValid),
  .outData    (outData),
  .outOvf     (outOvf),
  .outInexact (outInexact)
);

// File: tb/fixq_top_tb.sv
module fixq_top_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [23:0] inData = '0;
  logic [1:0]  quantMode = '0;
  logic [1:0]  ovfMode = '0;
  logic        outValid;
  logic [7:0]  outData;
  logic        outOvf;
  logic        outInexact;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  fixq_top u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .quantMode(quantMode), .ovfMode(ovfMode), .outValid(outValid),
    .outData(outData), .outOvf(outOvf), .outInexact(outInexact)
  );

  function automatic void model(input logic [23:0] d, input logic [1:0] qm,
                                input logic [1:0] om, output logic [7:0] r,
                                output logic o, output logic ix);
    longint v, fl, fr, q;
    v  = longint'($signed(d));
    fl = v >>> 9;
    fr = v - fl * 512;
    ix = (fr != 0);
    if (qm == 2'd1)      q = (v < 0 && fr != 0) ? fl + 1 : fl;
    else if (qm == 2'd2) q = fl;
    else                 q = fl + ((fr >= 256) ? 1 : 0);
    o = (q > 127) || (q < -128);
    if (!o)              r = 8'(q);
    else if (om == 2'd1) r = 8'h00;
    else if (om == 2'd2) r = 8'(q);
    else                 r = (q > 127) ? 8'h7F : 8'h80;
  endfunction

  task automatic check(input string tag, input logic [7:0] gd, input logic go,
                       input logic gi, input logic gv, input logic [7:0] ed,
                       input logic eo, input logic ei, input logic ev);
    checks++;
    if (gd !== ed || go !== eo || gi !== ei || gv !== ev) begin
      fails++;
      $display("FAIL %s: got data=%h ovf=%b inex=%b vld=%b, expected data=%h ovf=%b inex=%b vld=%b",
               tag, gd, go, gi, gv, ed, eo, ei, ev);
    end
  endtask

  task automatic apply(input string tag, input logic [23:0] d,
                       input logic [1:0] qm, input logic [1:0] om);
    logic [7:0] er;
    logic eo, ei;
    model(d, qm, om, er, eo, ei);
    inValid = 1'b1; inData = d; quantMode = qm; ovfMode = om;
    @(negedge clk);
    check(tag, outData, outOvf, outInexact, outValid, er, eo, ei, 1'b1);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] hd;
    logic ho, hi;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset", outData, outOvf, outInexact, outValid, 8'h00, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);

    // R3: half step on both signs
    apply("R3 round +half", 24'h000100, 2'd0, 2'd0);
    apply("R3 round -half", 24'hFFFF00, 2'd0, 2'd0);
    apply("R3 round below half", 24'h0002FF, 2'd0, 2'd0);
    // R4: toward zero
    apply("R4 zero neg", 24'hFFFFFF, 2'd1, 2'd0);
    apply("R4 zero pos", 24'h0003FF, 2'd1, 2'd0);
    // R5: truncate
    apply("R5 trunc neg", 24'hFFFF00, 2'd2, 2'd0);
    apply("R5 trunc pos", 24'h0003FF, 2'd2, 2'd0);
    // R9: round-up carry leaves the range
    apply("R9 carry sat", 24'h00FF00, 2'd0, 2'd0);
    apply("R9 carry wrap", 24'h00FF00, 2'd0, 2'd2);
    // R6 / R7 / R8: extremes
    apply("R6 sat hi", 24'h7FFFFF, 2'd2, 2'd0);
    apply("R6 sat lo", 24'h800000, 2'd2, 2'd0);
    apply("R7 satz hi", 24'h020000, 2'd2, 2'd1);
    apply("R7 satz lo", 24'hFE0000, 2'd2, 2'd1);
    apply("R8 wrap", 24'h012345, 2'd2, 2'd2);
    apply("R8 exact min", 24'hFF0000, 2'd2, 2'd1);
    // R10: inexact
    apply("R10 exact", 24'h004600, 2'd0, 2'd0);
    apply("R10 lsb", 24'h004601, 2'd0, 2'd0);
    // R11: code 3
    apply("R11 q3 half", 24'hFFFF00, 2'd3, 2'd0);
    apply("R11 o3 sat", 24'h7FFFFF, 2'd2, 2'd3);

    // R2: hold while inValid low
    model(24'h0002FF, 2'd3, 2'd3, hd, ho, hi);
    apply("R2 load", 24'h0002FF, 2'd3, 2'd3);
    inValid = 1'b0; inData = 24'h7FFFFF; quantMode = 2'd2; ovfMode = 2'd1;
    @(negedge clk);
    check("R2 hold 1", outData, outOvf, outInexact, outValid, hd, ho, hi, 1'b0);
    @(negedge clk);
    check("R2 hold 2", outData, outOvf, outInexact, outValid, hd, ho, hi, 1'b0);

    // Random mix, covering R3-R11
    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      logic [23:0] d;
      d = 24'($urandom);
      if ($urandom_range(0, 1) == 1) d = {{8{d[16]}}, d[15:0]};
      apply("R3-R11 random", d, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)));
    end
    inValid = 1'b0;
    @(negedge clk);
    check("R2 valid drop", outData, outOvf, outInexact, outValid,
          outData, outOvf, outInexact, 1'b0);

    // R1: mid-run reset
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset again", outData, outOvf, outInexact, outValid, 8'h00, 1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule